// File: doc/BRIEF.md
# Linear CCD Line Timing Controller

This block runs a linear CCD line sensor from a fast system clock. On a line-start request it performs a charge-transfer sequence. The sequence is a quiet guard period, a transfer-gate pulse, and a second quiet guard period. After that it emits one shift clock per pixel for a fixed line. The line is a run of leading dummy pixels, then the effective pixels, then a run of trailing dummy pixels. A window of optical-black pixels sits inside the leading dummies. The block also drives the reset/sample-hold pin of the sensor according to a static mode. In external-reset mode that pin carries a reset pulse once per pixel.

Every shift-clock rise is matched by a registered pixel index and region tag, so a downstream ADC capture path can label each sample without its own counter. A flag marks the even pixels of a small black-level reference set. All guard times and pulse widths are system-clock cycle counts on input ports. They are compared with minimum cycle counts derived from the system clock period. A configuration that is too short raises an error and blocks new lines.

A request that arrives during a line is held, and the next line starts as soon as the current one ends.

Top module: `ccd_line_timing`

## Requirements
- R1: While reset is asserted, every output is 0 except cfg_err_o, which is 1.
- R2: A start accepted at clock edge 0 raises busy_o at that edge. xfer_gate_o is high for edges [P, P+W), with P = rog_lead_i and W = rog_width_i. shift_clk_o stays low from edge 0 until the first pixel.
- R3: With Q = rog_trail_i and H = clk_half_i, the first shift_clk_o rise comes at edge B = P+W+Q. Each pixel then lasts 2H cycles: H cycles high, then H cycles low.
- R4: A line has LINE_PIX = LEAD_PIX+EFF_PIX+TRAIL_PIX pixels. pix_valid_o is high through the whole shifting period. pix_idx_o counts 1 to LINE_PIX and changes on the same edge as each shift_clk_o rise. Outside shifting, pix_idx_o is 0.
- R5: region_o codes are 0 = no pixel, 1 = leading dummy, 2 = optical black, 3 = effective, 4 = trailing dummy. Pixels 1..LEAD_PIX are leading dummies. Within them, OB_START..OB_START+OB_PIX-1 are optical black. The next EFF_PIX pixels are effective, and the rest are trailing.
- R6: black_ref_o is high for even pixel indices from REF_FIRST to REF_LAST, and low otherwise.
- R7: At edge E = B+2H·LINE_PIX, line_done_o is high for exactly one cycle. busy_o falls at that edge unless a request is pending.
- R8: A line_start_i seen while busy is held. The next line then begins at edge E, and that edge counts as edge 0 of the new line.
- R9: The mode_i code selects the outputs as follows. Code 0 gives ext_rs_sel_o = 0 and reset_hold_o = 0. Code 1 gives ext_rs_sel_o = 0 and reset_hold_o = 1. Code 2 gives ext_rs_sel_o = 1 and reset_hold_o carrying the reset pulse. Code 3 behaves as code 0.
- R10: In mode 2, reset_hold_o is low for the first L = rs_low_i cycles of each pixel's low phase, and high at all other times.
- R11: cfg_err_o is 1 one edge after any setting is below its minimum, or rs_low_i > clk_half_i. The minimums in cycles are ceil(200/T) for the lead guard, ceil(1200/T) for the gate width and for the trail guard, ceil(40/T) for a half period and ceil(25/T) for the reset low time, where T = SYS_PERIOD_NS. While cfg_err_o is 1, a line start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Request one line |
| mode_i | input | 2 | Output mode code (static) |
| clk_half_i | input | CW | Shift clock half period, cycles |
| rog_lead_i | input | CW | Quiet time before transfer gate, cycles |
| rog_width_i | input | CW | Transfer gate width, cycles |
| rog_trail_i | input | CW | Quiet time after transfer gate, cycles |
| rs_low_i | input | CW | Reset pulse low time, cycles |
| shift_clk_o | output | 1 | Sensor pixel shift clock |
| xfer_gate_o | output | 1 | Sensor transfer gate pulse |
| reset_hold_o | output | 1 | Reset pulse or sample-hold select level |
| ext_rs_sel_o | output | 1 | Reset source select level (1 = external) |
| pix_valid_o | output | 1 | A pixel is being shifted out |
| pix_idx_o | output | PW | Pixel index, 1-based |
| region_o | output | 3 | Region code of the current pixel |
| black_ref_o | output | 1 | Pixel belongs to the even black reference set |
| busy_o | output | 1 | A line sequence is active |
| line_done_o | output | 1 | One-cycle end-of-line strobe |
| cfg_err_o | output | 1 | Timing settings below minimum |

## Verification
Every sensor and tag output is registered from the next-state decode. A result therefore appears at the same edge that moves the sequencer, and nothing lags by an extra cycle. The bench numbers edges from the one that samples the request. At each falling edge after edge k it works out the expected levels arithmetically from P, W, Q, H, L and the pixel geometry, using the offsets P, P+W, B and E. cfg_err_o is due one edge after a setting changes, so the bench waits three cycles after reconfiguring before it requests a line.

// File: rtl/ccd_line_timing_pkg.sv
package ccd_line_timing_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_GATE, ST_TRAIL, ST_SHIFT
  } seq_st_e;

  localparam logic [2:0] REG_NONE  = 3'd0;
  localparam logic [2:0] REG_LEAD  = 3'd1;
  localparam logic [2:0] REG_BLACK = 3'd2;
  localparam logic [2:0] REG_EFF   = 3'd3;
  localparam logic [2:0] REG_TRAIL = 3'd4;

  localparam logic [1:0] MODE_INT    = 2'd0;
  localparam logic [1:0] MODE_INT_SH = 2'd1;
  localparam logic [1:0] MODE_EXT    = 2'd2;
endpackage

// File: rtl/ccd_line_timing_cfg.sv
module ccd_line_timing_cfg #(
  parameter int SYS_PERIOD_NS = 10,
  parameter int CW            = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] clk_half_i,
  input  logic [CW-1:0] rog_lead_i,
  input  logic [CW-1:0] rog_width_i,
  input  logic [CW-1:0] rog_trail_i,
  input  logic [CW-1:0] rs_low_i,
  output logic          err_o
);
  localparam logic [CW-1:0] MIN_HALF  = CW'((40   + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS);
  localparam logic [CW-1:0] MIN_LEAD  = CW'((200  + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS);
  localparam logic [CW-1:0] MIN_GATE  = CW'((1200 + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS);
  localparam logic [CW-1:0] MIN_TRAIL = CW'((1200 + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS);
  localparam logic [CW-1:0] MIN_RS    = CW'((25   + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS);

  logic bad;
  assign bad = (clk_half_i < MIN_HALF) || (rog_lead_i < MIN_LEAD) ||
               (rog_width_i < MIN_GATE) || (rog_trail_i < MIN_TRAIL) ||
               (rs_low_i < MIN_RS) || (rs_low_i > clk_half_i);

  // reset high: no line may start before the settings are judged
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b1;
    else         err_o <= bad;
  end
endmodule

// File: rtl/ccd_line_timing_seq.sv
module ccd_line_timing_seq
  import ccd_line_timing_pkg::*;
#(
  parameter int CW       = 8,
  parameter int PW       = 13,
  parameter int LINE_PIX = 8042
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cfg_err_i,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] clk_half_i,
  input  logic [CW-1:0] rog_lead_i,
  input  logic [CW-1:0] rog_width_i,
  input  logic [CW-1:0] rog_trail_i,
  input  logic [CW-1:0] rs_low_i,
  output logic          shift_clk_o,
  output logic          xfer_gate_o,
  output logic          reset_hold_o,
  output logic          ext_sel_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pix_valid_o,
  output logic [PW-1:0] pix_idx_o,
  output logic          pix_load_o,
  output logic [PW-1:0] pix_nxt_o
);
  localparam logic [PW-1:0] LAST_PIX = PW'(LINE_PIX);
  localparam logic [CW-1:0] ONE      = CW'(1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] pix_q, pix_d;
  logic          ph_q, ph_d, pend_q, pend_d, done_d, go, rs_low_d;

  assign go = (start_i | pend_q) & ~cfg_err_i;

  always_comb begin
    st_d   = st_q;
    tmr_d  = (tmr_q != '0) ? tmr_q - ONE : tmr_q;
    pix_d  = pix_q;
    ph_d   = ph_q;
    done_d = 1'b0;
    pend_d = pend_q | (start_i && st_q != ST_IDLE);
    unique case (st_q)
      ST_IDLE: if (go) begin
        st_d = ST_LEAD; tmr_d = rog_lead_i - ONE; pend_d = 1'b0;
      end
      ST_LEAD: if (tmr_q == '0) begin
        st_d = ST_GATE; tmr_d = rog_width_i - ONE;
      end
      ST_GATE: if (tmr_q == '0) begin
        st_d = ST_TRAIL; tmr_d = rog_trail_i - ONE;
      end
      ST_TRAIL: if (tmr_q == '0) begin
        st_d = ST_SHIFT; tmr_d = clk_half_i - ONE; pix_d = PW'(1); ph_d = 1'b0;
      end
      ST_SHIFT: if (tmr_q == '0) begin
        if (!ph_q) begin
          ph_d = 1'b1; tmr_d = clk_half_i - ONE;
        end else if (pix_q == LAST_PIX) begin
          done_d = 1'b1;
          pix_d  = '0;
          if (go) begin
            st_d = ST_LEAD; tmr_d = rog_lead_i - ONE; pend_d = 1'b0;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          pix_d = pix_q + PW'(1); ph_d = 1'b0; tmr_d = clk_half_i - ONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // low phase index j = half-1-tmr; pulse while j < rs_low
  assign rs_low_d   = (st_d == ST_SHIFT) && ph_d && (tmr_d >= clk_half_i - rs_low_i);
  assign pix_load_o = (st_d == ST_SHIFT);
  assign pix_nxt_o  = pix_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; tmr_q <= '0; pix_q <= '0; ph_q <= 1'b0; pend_q <= 1'b0;
      shift_clk_o <= 1'b0; xfer_gate_o <= 1'b0; reset_hold_o <= 1'b0; ext_sel_o <= 1'b0;
      busy_o <= 1'b0; done_o <= 1'b0; pix_valid_o <= 1'b0; pix_idx_o <= '0;
    end else begin
      st_q <= st_d; tmr_q <= tmr_d; pix_q <= pix_d; ph_q <= ph_d; pend_q <= pend_d;
      shift_clk_o  <= (st_d == ST_SHIFT) && !ph_d;
      xfer_gate_o  <= (st_d == ST_GATE);
      ext_sel_o    <= (mode_i == MODE_EXT);
      reset_hold_o <= (mode_i == MODE_EXT) ? ~rs_low_d : (mode_i == MODE_INT_SH);
      busy_o       <= (st_d != ST_IDLE);
      done_o       <= done_d;
      pix_valid_o  <= (st_d == ST_SHIFT);
      pix_idx_o    <= (st_d == ST_SHIFT) ? pix_d : '0;
    end
  end
endmodule

// File: rtl/ccd_line_timing_tag.sv
module ccd_line_timing_tag
  import ccd_line_timing_pkg::*;
#(
  parameter int PW        = 13,
  parameter int LEAD_PIX  = 98,
  parameter int OB_START  = 7,
  parameter int OB_PIX    = 80,
  parameter int EFF_PIX   = 7926,
  parameter int REF_FIRST = 8,
  parameter int REF_LAST  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] pix_i,
  output logic [2:0]    region_o,
  output logic          ref_o
);
  localparam logic [PW-1:0] LEAD_END = PW'(LEAD_PIX);
  localparam logic [PW-1:0] EFF_END  = PW'(LEAD_PIX + EFF_PIX);
  localparam logic [PW-1:0] REF_LO   = PW'(REF_FIRST);
  localparam logic [PW-1:0] REF_HI   = PW'(REF_LAST);

  logic       in_black;
  logic [2:0] region_d;
  logic       ref_d;

  generate
    if (OB_PIX > 0) begin : g_black
      localparam logic [PW-1:0] OB_LO = PW'(OB_START);
      localparam logic [PW-1:0] OB_HI = PW'(OB_START + OB_PIX - 1);
      assign in_black = (pix_i >= OB_LO) && (pix_i <= OB_HI);
    end else begin : g_no_black
      assign in_black = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!load_i)               region_d = REG_NONE;
    else if (pix_i <= LEAD_END) region_d = in_black ? REG_BLACK : REG_LEAD;
    else if (pix_i <= EFF_END)  region_d = REG_EFF;
    else                        region_d = REG_TRAIL;
  end

  assign ref_d = load_i && !pix_i[0] && (pix_i >= REF_LO) && (pix_i <= REF_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_o <= REG_NONE;
      ref_o    <= 1'b0;
    end else begin
      region_o <= region_d;
      ref_o    <= ref_d;
    end
  end
endmodule

// File: rtl/ccd_line_timing.sv
module ccd_line_timing #(
  parameter int SYS_PERIOD_NS = 10,
  parameter int CW            = 8,
  parameter int LEAD_PIX      = 98,
  parameter int OB_START      = 7,
  parameter int OB_PIX        = 80,
  parameter int EFF_PIX       = 7926,
  parameter int TRAIL_PIX     = 18,
  parameter int REF_FIRST     = 8,
  parameter int REF_LAST      = 16,
  localparam int LINE_PIX     = LEAD_PIX + EFF_PIX + TRAIL_PIX,
  localparam int PW           = $clog2(LINE_PIX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_start_i,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] clk_half_i,
  input  logic [CW-1:0] rog_lead_i,
  input  logic [CW-1:0] rog_width_i,
  input  logic [CW-1:0] rog_trail_i,
  input  logic [CW-1:0] rs_low_i,
  output logic          shift_clk_o,
  output logic          xfer_gate_o,
  output logic          reset_hold_o,
  output logic          ext_rs_sel_o,
  output logic          pix_valid_o,
  output logic [PW-1:0] pix_idx_o,
  output logic [2:0]    region_o,
  output logic          black_ref_o,
  output logic          busy_o,
  output logic          line_done_o,
  output logic          cfg_err_o
);
  logic          pix_load;
  logic [PW-1:0] pix_nxt;

  ccd_line_timing_cfg #(.SYS_PERIOD_NS(SYS_PERIOD_NS), .CW(CW)) u_cfg (
    .clk_i, .rst_ni, .clk_half_i, .rog_lead_i, .rog_width_i, .rog_trail_i,
    .rs_low_i, .err_o(cfg_err_o)
  );

  ccd_line_timing_seq #(.CW(CW), .PW(PW), .LINE_PIX(LINE_PIX)) u_seq (
    .clk_i, .rst_ni, .start_i(line_start_i), .cfg_err_i(cfg_err_o), .mode_i,
    .clk_half_i, .rog_lead_i, .rog_width_i, .rog_trail_i, .rs_low_i,
    .shift_clk_o, .xfer_gate_o, .reset_hold_o, .ext_sel_o(ext_rs_sel_o),
    .busy_o, .done_o(line_done_o), .pix_valid_o, .pix_idx_o,
    .pix_load_o(pix_load), .pix_nxt_o(pix_nxt)
  );

  ccd_line_timing_tag #(
    .PW(PW), .LEAD_PIX(LEAD_PIX), .OB_START(OB_START), .OB_PIX(OB_PIX),
    .EFF_PIX(EFF_PIX), .REF_FIRST(REF_FIRST), .REF_LAST(REF_LAST)
  ) u_tag (
    .clk_i, .rst_ni, .load_i(pix_load), .pix_i(pix_nxt),
    .region_o, .ref_o(black_ref_o)
  );
endmodule

// File: rtl/ccd_line_timing_chk.sv
module ccd_line_timing_chk #(
  parameter int PW       = 13,
  parameter int LINE_PIX = 8042
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          shift_clk_o,
  input logic          xfer_gate_o,
  input logic          reset_hold_o,
  input logic          ext_rs_sel_o,
  input logic          pix_valid_o,
  input logic [PW-1:0] pix_idx_o,
  input logic [2:0]    region_o,
  input logic          busy_o,
  input logic          line_done_o,
  input logic          cfg_err_o
);
  assert_gate_no_clk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_gate_o |-> !shift_clk_o && !pix_valid_o && busy_o);

  assert_clk_rise_tag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shift_clk_o) |-> pix_valid_o && (pix_idx_o != $past(pix_idx_o)));

  assert_idx_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_idx_o >= PW'(1)) && (pix_idx_o <= PW'(LINE_PIX)));

  assert_region_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (region_o != 3'd0));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o);

  assert_done_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> ($past(pix_idx_o) == PW'(LINE_PIX)) && !pix_valid_o);

  assert_rs_in_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rs_sel_o && !reset_hold_o) |-> !shift_clk_o && pix_valid_o);

  assert_cfg_block_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !busy_o) |=> !busy_o);
endmodule

bind ccd_line_timing ccd_line_timing_chk #(.PW(PW), .LINE_PIX(LINE_PIX)) u_chk (
  .clk_i, .rst_ni, .shift_clk_o, .xfer_gate_o, .reset_hold_o, .ext_rs_sel_o,
  .pix_valid_o, .pix_idx_o, .region_o, .busy_o, .line_done_o, .cfg_err_o
);

// File: tb/ccd_line_timing_bench.sv
module ccd_line_timing_bench;
  localparam int CLK_PERIOD = 40;
  localparam int LEAD = 6, OBS = 2, OBL = 3, EFF = 8, TRAIL = 3;
  localparam int REF_LO = 2, REF_HI = 4, CW = 8;
  localparam int NPIX = LEAD + EFF + TRAIL;
  localparam int PW = $clog2(NPIX + 1);
  localparam int MIN_GATE = 30;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] md = 2'd0;
  logic [CW-1:0] half_s = 8'd1, lead_s = 8'd5, width_s = 8'd30, trail_s = 8'd30, rsl_s = 8'd1;
  logic shift_clk, gate, hold, ext_sel, pvalid, bref, busy, done, cerr;
  logic [PW-1:0] pidx;
  logic [2:0] region;
  int n_chk = 0, n_fail = 0;
  int P, W, Q, H, L;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_line_timing #(
    .SYS_PERIOD_NS(CLK_PERIOD), .CW(CW), .LEAD_PIX(LEAD), .OB_START(OBS), .OB_PIX(OBL),
    .EFF_PIX(EFF), .TRAIL_PIX(TRAIL), .REF_FIRST(REF_LO), .REF_LAST(REF_HI)
  ) u_ccd_line_timing (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(start), .mode_i(md),
    .clk_half_i(half_s), .rog_lead_i(lead_s), .rog_width_i(width_s),
    .rog_trail_i(trail_s), .rs_low_i(rsl_s),
    .shift_clk_o(shift_clk), .xfer_gate_o(gate), .reset_hold_o(hold),
    .ext_rs_sel_o(ext_sel), .pix_valid_o(pvalid), .pix_idx_o(pidx),
    .region_o(region), .black_ref_o(bref), .busy_o(busy),
    .line_done_o(done), .cfg_err_o(cerr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_region(input int p);
    if (p <= LEAD) return (p >= OBS && p < OBS + OBL) ? 2 : 1;
    if (p <= LEAD + EFF) return 3;
    return 4;
  endfunction

  task automatic check_cycle(input int k, input bit pend);
    int b, e, off, p, r;
    bit sh, clk_e, rsl;
    b = P + W + Q;
    e = b + NPIX * 2 * H;
    sh = (k >= b) && (k < e);
    off = k - b;
    p = sh ? off / (2 * H) + 1 : 0;
    r = sh ? off % (2 * H) : 0;
    clk_e = sh && (r < H);
    rsl = sh && (r >= H) && (r < H + L);
    chk("R2 busy", busy, (k < e) ? 1 : int'(pend));
    chk("R2 gate", gate, (k >= P && k < P + W) ? 1 : 0);
    chk("R3 shift_clk", shift_clk, clk_e ? 1 : 0);
    chk("R4 pix_valid", pvalid, sh ? 1 : 0);
    chk("R4 pix_idx", pidx, p);
    chk("R5 region", region, sh ? exp_region(p) : 0);
    chk("R6 black_ref", bref, (sh && p % 2 == 0 && p >= REF_LO && p <= REF_HI) ? 1 : 0);
    chk("R7 line_done", done, (k == e) ? 1 : 0);
    chk("R9 ext_sel", ext_sel, (md == 2'd2) ? 1 : 0);
    if (md == 2'd2) chk("R10 reset_hold", hold, rsl ? 0 : 1);
    else            chk("R9 reset_hold", hold, (md == 2'd1) ? 1 : 0);
  endtask

  task automatic configure(input int p_, input int w_, input int q_, input int h_,
                           input int l_, input int m_);
    P = p_; W = w_; Q = q_; H = h_; L = l_;
    lead_s = CW'(p_); width_s = CW'(w_); trail_s = CW'(q_); half_s = CW'(h_);
    rsl_s = CW'(l_); md = 2'(m_);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_line(input bit pend_mid);
    int b, e;
    b = P + W + Q;
    e = b + NPIX * 2 * H;
    chk("R11 cfg_err clear", cerr, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_cycle(0, pend_mid);
    for (int k = 1; k <= e; k++) begin
      @(negedge clk);
      start = 1'b0;
      check_cycle(k, pend_mid);
      if (pend_mid && k == b) start = 1'b1; // R8 request during shifting
    end
    if (pend_mid) begin // R8 new line: edge E is its edge 0
      for (int k = 1; k <= e; k++) begin
        @(negedge clk);
        check_cycle(k, 1'b0);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_blocked(input string what);
    chk({"R11 cfg_err ", what}, cerr, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R11 start ignored", busy, 0);
      chk("R11 gate idle", gate, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 shift_clk", shift_clk, 0); chk("R1 gate", gate, 0);
    chk("R1 hold", hold, 0);           chk("R1 ext_sel", ext_sel, 0);
    chk("R1 pix_valid", pvalid, 0);    chk("R1 pix_idx", pidx, 0);
    chk("R1 region", region, 0);       chk("R1 black_ref", bref, 0);
    chk("R1 busy", busy, 0);           chk("R1 line_done", done, 0);
    chk("R1 cfg_err", cerr, 1);
    rst_n = 1'b1;

    // sweep half period, mode and reset low width
    for (int h = 1; h <= 3; h++)
      for (int m = 0; m < 4; m++) begin
        configure(5 + h, MIN_GATE + m, MIN_GATE + 2 * h, h, 1 + (m % h), m);
        run_line(1'b0);
      end

    // R8 back-to-back line from a held request
    configure(7, 31, 32, 2, 2, 2);
    run_line(1'b1);

    // R11 settings below minimum are rejected
    configure(5, MIN_GATE - 1, 30, 1, 1, 0);
    expect_blocked("gate short");
    configure(4, 30, 30, 1, 1, 0);
    expect_blocked("lead short");
    configure(5, 30, MIN_GATE - 1, 1, 1, 0);
    expect_blocked("trail short");
    configure(5, 30, 30, 0, 0, 0);
    expect_blocked("half zero");
    configure(5, 30, 30, 2, 3, 2);
    expect_blocked("rs above half");
    configure(5, 30, 30, 1, 1, 1);
    run_line(1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule